// File: doc/BRIEF.md
# Serial Management Target with Emulated PHY Registers

This block plays the part of a PHY's management slave for a host that drives the serial management lines in software. Each write to a control register carries a clock bit, a data-out bit and a read-direction bit. The block counts rising edges of the clock bit across successive control writes. On each edge it shifts the data-out bit into a 32-bit word. When enough bits have arrived it decodes the word as a read frame or a write frame. Read data goes back out on a single data-in bit.

No start pattern is searched for. A frame is recognised purely by how many bits have been counted. A run of ones long enough to fill the word clears the count, so the usual preamble resynchronises the target.

Behind the serial engine sits a bank of 32 sixteen-bit PHY registers. Each register has a fixed reset value and a fixed write mask. Only one PHY address answers.

Top module: `mii_mgmt_target`

## Requirements
- R1: Frame state advances only on a control write whose clock bit is 1 when the clock bit of the previous control write was 0; at reset the previous clock bit counts as 0. Any other control write, or any cycle without a control write, leaves the bit count, the shift word and the register bank unchanged.
- R2: On each rising edge the bit count goes up by one, saturating at its maximum, and the shift word moves left by one. The new bit 0 is the data-out bit when the new count is below 16 or the read-direction bit is 0; otherwise the new bit 0 is 0.
- R3: When the shift word becomes all ones, the bit count returns to 0, so 32 edges with data-out at 1 act as a preamble from any state.
- R4: When the count reaches 16, bits 15:12 of the word are taken as the opcode, bits 11:7 as the PHY address and bits 6:2 as the register number. Opcode 6 replaces the word with the addressed register value, zero-extended. The data-in bit then takes bit 15 of the shifted word on every edge whose new count is 16 or more while the read-direction bit is 1. A read frame therefore presents register bits 14 down to 0 on edges 17 to 31.
- R5: When the count reaches 32, bits 31:28 are taken as the opcode, bits 27:23 as the PHY address, bits 22:18 as the register number and bits 15:0 as the data. Opcode 5 writes that data.
- R6: Only PHY address PHY_ADDR (default 1) responds. A read at any other address loads 0, and a write to any other address changes no register.
- R7: A write changes only the bits set in the target register's write mask. The masks are: register 0 0xFFFF; registers 1, 2, 3, 5 and 6 0x0000; register 4 0xC01F; register 16 0x0FFF; every other register 0xFFFF.
- R8: After reset the registers hold: register 0 0x3100, register 1 0xF02C, register 2 0x7810, register 4 0x0501, register 5 0x4181, register 16 0x0003, register 18 0x0001, and 0 for every other register.
- R9: The data-in bit is 0 after reset. It keeps its value through every control write except the edges named in R4, so the host cannot overwrite returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe, one cycle per write |
| ctl_mdc | input | 1 | Management clock bit of the written value |
| ctl_mdo | input | 1 | Data-out bit of the written value |
| ctl_rd_dir | input | 1 | Read-direction bit of the written value |
| mdi | output | 1 | Data-in bit returned to the host |

## Verification
The bench builds the block with its defaults: PHY address 1 and a 6-bit saturating edge counter. With these defaults, full read and write frames reach every register number. A second PHY address, 2, is also in reach, so the bench can exercise the silent-address cases. The saturating counter covers the 32-edge preamble that follows each completed frame. Random writes target registers that are fully writable and registers that are partly masked. Directed frames cover the reset values and the read-only register. They also cover held-high and falling clock writes inside a frame, and a partial frame that is abandoned and recovered by the preamble.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

    localparam int FRAME_W  = 32;
    localparam int HDR_BITS = 16;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int NUM_REGS = 2 ** ADDR_W;

    localparam logic [3:0] OP_READ  = 4'd6;
    localparam logic [3:0] OP_WRITE = 4'd5;

    typedef logic [FRAME_W-1:0] frame_word_t;
    typedef logic [DATA_W-1:0]  reg_val_t;

    typedef struct packed {
        logic [3:0]        op;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regn;
    } mgmt_hdr_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regn;
        reg_val_t          data;
    } mgmt_wr_t;

    // Header of a frame once 16 bits have arrived
    function automatic mgmt_hdr_t hdr_short(frame_word_t w);
        mgmt_hdr_t h;
        h.op   = w[15:12];
        h.phy  = w[11:7];
        h.regn = w[6:2];
        return h;
    endfunction

    // Header of a frame once 32 bits have arrived
    function automatic mgmt_hdr_t hdr_long(frame_word_t w);
        mgmt_hdr_t h;
        h.op   = w[31:28];
        h.phy  = w[27:23];
        h.regn = w[22:18];
        return h;
    endfunction

    function automatic reg_val_t reg_default(int idx);
        case (idx)
            0:       return 16'h3100;
            1:       return 16'hF02C;
            2:       return 16'h7810;
            4:       return 16'h0501;
            5:       return 16'h4181;
            16:      return 16'h0003;
            18:      return 16'h0001;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic reg_val_t reg_wmask(int idx);
        case (idx)
            1, 2, 3, 5, 6: return 16'h0000;
            4:             return 16'hC01F;
            16:            return 16'h0FFF;
            default:       return 16'hFFFF;
        endcase
    endfunction

endpackage

// File: rtl/mgmt_clk_edge.sv
module mgmt_clk_edge (
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  logic mdc,
    output logic rise
);
    logic mdc_prev;

    assign rise = we && mdc && !mdc_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_prev <= 1'b0;
        end else if (we) begin
            mdc_prev <= mdc;
        end
    end

endmodule

// File: rtl/mgmt_shift_engine.sv
module mgmt_shift_engine
    import mii_mgmt_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              mdo,
    input  logic              rd_dir,
    output logic [ADDR_W-1:0] rd_phy,
    output logic [ADDR_W-1:0] rd_addr,
    input  reg_val_t          rd_data,
    output mgmt_wr_t          wr,
    output logic              mdi
);
    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_HDR   = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] CNT_FRAME = CNT_W'(FRAME_W);

    logic [CNT_W-1:0] cnt, cnt_inc, cnt_n;
    frame_word_t      word, shifted, word_n;
    logic             mdi_q, mdi_n;
    mgmt_hdr_t        h16, h32;

    always_comb begin
        cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
        shifted = {word[FRAME_W-2:0], mdo && ((cnt_inc < CNT_HDR) || !rd_dir)};
        h16     = hdr_short(shifted);
        h32     = hdr_long(shifted);
        rd_phy  = h16.phy;
        rd_addr = h16.regn;

        mdi_n = mdi_q;
        if ((cnt_inc >= CNT_HDR) && rd_dir) begin
            mdi_n = shifted[HDR_BITS-1];
        end

        cnt_n    = cnt_inc;
        word_n   = shifted;
        wr       = '0;
        wr.phy   = h32.phy;
        wr.regn  = h32.regn;
        wr.data  = shifted[DATA_W-1:0];
        if (&shifted) begin
            cnt_n = '0;
        end else if (cnt_inc == CNT_HDR) begin
            if (h16.op == OP_READ) begin
                word_n = {{(FRAME_W-DATA_W){1'b0}}, rd_data};
            end
        end else if (cnt_inc == CNT_FRAME) begin
            wr.valid = rise && (h32.op == OP_WRITE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            word  <= '0;
            mdi_q <= 1'b0;
        end else if (rise) begin
            cnt   <= cnt_n;
            word  <= word_n;
            mdi_q <= mdi_n;
        end
    end

    assign mdi = mdi_q;

    // R1: without a rising clock bit the frame state is frozen
    assert_hold_no_edge_R1: assert property (@(posedge clk) disable iff (rst)
        !rise |=> ($stable(cnt) && $stable(word)));

    // R2 / R3: an edge either counts up by one or restarts on a preamble
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (rise && cnt != CNT_MAX) |=> ((cnt == $past(cnt) + 1'b1) || (cnt == '0)));

    // R9: returned data survives every write that is not an edge
    assert_mdi_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(mdi_q));

endmodule

// File: rtl/mgmt_phy_regfile.sv
module mgmt_phy_regfile
    import mii_mgmt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PHY_ADDR = 5'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_phy,
    input  logic [ADDR_W-1:0] rd_addr,
    output reg_val_t          rd_data,
    input  mgmt_wr_t          wr
);
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic [NUM_REGS-1:0][DATA_W-1:0] def_vec;
    logic [NUM_REGS-1:0][DATA_W-1:0] msk_vec;
    logic                            hit;
    reg_val_t                        cur, msk;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_const
        assign def_vec[i] = reg_default(i);
        assign msk_vec[i] = reg_wmask(i);
    end

    assign rd_data = (rd_phy == PHY_ADDR) ? regs[rd_addr] : '0;
    assign hit     = wr.valid && (wr.phy == PHY_ADDR);
    assign cur     = regs[wr.regn];
    assign msk     = msk_vec[wr.regn];

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= def_vec;
        end else if (hit) begin
            regs[wr.regn] <= (cur & ~msk) | (wr.data & msk);
        end
    end

    // R6: a write addressed to another PHY leaves the bank untouched
    assert_foreign_phy_R6: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && wr.phy != PHY_ADDR) |=> $stable(regs));

    // R7: the identifier register never changes
    assert_readonly_id_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(regs[1]));

endmodule

// File: rtl/mii_mgmt_target.sv
module mii_mgmt_target
    import mii_mgmt_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'd1,
    parameter int         CNT_W    = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic ctl_we,
    input  logic ctl_mdc,
    input  logic ctl_mdo,
    input  logic ctl_rd_dir,
    output logic mdi
);
    logic              rise;
    logic [ADDR_W-1:0] rd_phy, rd_addr;
    reg_val_t          rd_data;
    mgmt_wr_t          wr;

    mgmt_clk_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .we   (ctl_we),
        .mdc  (ctl_mdc),
        .rise (rise)
    );

    mgmt_shift_engine #(.CNT_W(CNT_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .rise    (rise),
        .mdo     (ctl_mdo),
        .rd_dir  (ctl_rd_dir),
        .rd_phy  (rd_phy),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr      (wr),
        .mdi     (mdi)
    );

    mgmt_phy_regfile #(.PHY_ADDR(PHY_ADDR)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .rd_phy  (rd_phy),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr      (wr)
    );

endmodule

// File: tb/test_mii_mgmt_target.sv
module test_mii_mgmt_target;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_we = 1'b0, ctl_mdc = 1'b0, ctl_mdo = 1'b0, ctl_rd_dir = 1'b0;
    logic mdi;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [15:0] model [32];

    always #2 clk = ~clk;

    mii_mgmt_target i_mii_mgmt_target (
        .clk        (clk),
        .rst        (rst),
        .ctl_we     (ctl_we),
        .ctl_mdc    (ctl_mdc),
        .ctl_mdo    (ctl_mdo),
        .ctl_rd_dir (ctl_rd_dir),
        .mdi        (mdi)
    );

    function automatic logic [15:0] exp_default(int i);
        case (i)
            0: return 16'h3100;  1: return 16'hF02C;  2: return 16'h7810;
            4: return 16'h0501;  5: return 16'h4181; 16: return 16'h0003;
            18: return 16'h0001;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] exp_mask(int i);
        if (i == 1 || i == 2 || i == 3 || i == 5 || i == 6) return 16'h0000;
        if (i == 4) return 16'hC01F;
        if (i == 16) return 16'h0FFF;
        return 16'hFFFF;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic ctl(input logic c, input logic d, input logic r);
        @(negedge clk);
        ctl_we = 1'b1; ctl_mdc = c; ctl_mdo = d; ctl_rd_dir = r;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic bit_out(input logic d, input logic r);
        ctl(1'b0, d, r);
        ctl(1'b1, d, r);
    endtask

    task automatic preamble();
        for (int k = 0; k < 32; k++) bit_out(1'b1, 1'b0);
    endtask

    task automatic wr_frame(input logic [4:0] phy, input logic [4:0] rn, input logic [15:0] d);
        logic [31:0] f;
        f = {4'b0101, phy, rn, 2'b10, d};
        preamble();
        for (int k = 31; k >= 0; k--) bit_out(f[k], 1'b0);
    endtask

    // stall_at > 16: extra non-rising writes inserted after that edge
    task automatic rd_frame(input logic [4:0] phy, input logic [4:0] rn,
                            input int stall_at, output logic [14:0] val);
        logic [15:0] f;
        logic held;
        f = {4'b0110, phy, rn, 2'b10};
        preamble();
        for (int k = 15; k >= 0; k--) bit_out(f[k], 1'b0);
        for (int k = 17; k <= 32; k++) begin
            bit_out(1'b0, 1'b1);
            if (k <= 31) val[31-k] = mdi;
            if (k == stall_at) begin
                held = mdi;
                ctl(1'b1, 1'b1, 1'b0);   // clock bit already high
                ctl(1'b1, 1'b0, 1'b1);
                ctl(1'b0, 1'b1, 1'b0);   // falling only
                check("R9 data-in held over non-edge writes", 32'(mdi), 32'(held));
            end
        end
    endtask

    task automatic rd_check(input string req, input logic [4:0] phy, input int rn,
                            input logic [15:0] exp);
        logic [14:0] v;
        rd_frame(phy, 5'(rn), 0, v);
        check(req, 32'(v), 32'(exp[14:0]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [14:0] v;
        logic [15:0] d;
        int rn;
        int pick [7] = '{0, 4, 7, 9, 16, 21, 30};
        void'($urandom(32'd2024));
        for (int i = 0; i < 32; i++) model[i] = exp_default(i);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 data-in after reset", 32'(mdi), 32'd0);

        // R8 reset values, read through R4 frames
        rd_check("R8 reg0 default", 5'd1, 0, 16'h3100);
        rd_check("R8 reg1 default", 5'd1, 1, 16'hF02C);
        rd_check("R8 reg2 default", 5'd1, 2, 16'h7810);
        rd_check("R8 reg3 default", 5'd1, 3, 16'h0000);
        rd_check("R8 reg4 default", 5'd1, 4, 16'h0501);
        rd_check("R8 reg5 default", 5'd1, 5, 16'h4181);
        rd_check("R8 reg16 default", 5'd1, 16, 16'h0003);
        rd_check("R8 reg18 default", 5'd1, 18, 16'h0001);

        // R7 read-only register ignores writes
        wr_frame(5'd1, 5'd1, 16'h0ABC);
        rd_check("R7 reg1 read-only", 5'd1, 1, model[1]);

        // R7 partial mask on reg4
        wr_frame(5'd1, 5'd4, 16'hBFFF);
        model[4] = (model[4] & ~exp_mask(4)) | (16'hBFFF & exp_mask(4));
        rd_check("R7 reg4 masked write", 5'd1, 4, model[4]);

        // R6 other PHY address
        wr_frame(5'd2, 5'd0, 16'h0123);
        rd_check("R6 write to phy 2 ignored", 5'd1, 0, model[0]);
        rd_check("R6 read from phy 2 is zero", 5'd2, 0, 16'h0000);

        // R5 / R2 random writes and read back
        for (int i = 0; i < 10; i++) begin
            rn = pick[$urandom % 7];
            d = 16'($urandom);
            if (d[15:12] == 4'h5) d[15:12] = 4'h4;
            wr_frame(5'd1, 5'(rn), d);
            model[rn] = (model[rn] & ~exp_mask(rn)) | (d & exp_mask(rn));
            rd_check($sformatf("R5 random write reg%0d", rn), 5'd1, rn, model[rn]);
        end

        // R1 non-rising writes inside a read frame do not disturb it
        rd_frame(5'd1, 5'd5, 22, v);
        check("R1 read with stalls mid-frame", 32'(v), 32'(model[5][14:0]));

        // R3 abandoned partial frame recovered by preamble
        for (int k = 0; k < 7; k++) bit_out(1'($urandom), 1'b0);
        rd_check("R3 recovery after partial frame", 5'd1, 16, model[16]);

        // R9 data-in kept across preamble writes (read-direction clear)
        rd_frame(5'd1, 5'd2, 0, v);
        d[0] = mdi;
        preamble();
        check("R9 data-in held during preamble", 32'(mdi), 32'(d[0]));

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule